// File: doc/BRIEF.md
# Four-Port Output-Selection Router

This block is the arbitration core of a 4x4 packet switch. Every cycle each of the four input queues presents up to four head-of-line candidates (slots). Each candidate has a valid bit, a traffic class (priority or data), an 8-bit destination address and a 16-bit timestamp. Each input also reports how full its queue is. The destination address is first mapped to an output port through a 256-entry programmable table. Then each output port picks at most one candidate.

Priority traffic always wins over data traffic on an output. Among priority candidates, the one from the fullest input queue wins. Among data candidates, the one with the earliest timestamp wins. Both scans begin at a rotating start input and wrap around, so the start input settles ties. Grants and dequeue strobes are registered and appear one cycle after the candidates that produced them.

Top module: `rtsel_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every grant valid bit and every dequeue strobe is 0. Reset loads table entry k with k mod 4 (the two low address bits), and sets the start input to 0.
- R2: A candidate's output port is the table entry at its address. A table write (cfg_we=1, cfg_addr, cfg_port) is not seen by lookups in the cycle it is presented. It is seen from the next cycle on.
- R3: For each input and output, the input offers the lowest-numbered valid slot of each class that routes to that output. Slot s of input i sits at flat candidate index i*4+s.
- R4: An output with at least one priority candidate grants priority traffic (gnt_data=0). Data traffic (gnt_data=1) is granted only when no priority candidate routes to that output. cand_data=1 marks a data candidate.
- R5: Among priority candidates, inputs are scanned in the order start, start+1, … with wrap-around. The running choice is replaced only by a strictly larger occupancy, so a tie goes to the first input in scan order.
- R6: Among data candidates, the scan order is the same. The running choice is replaced only by a strictly earlier timestamp, where A is earlier than B when (B−A) mod 65536 is nonzero and below 32768.
- R7: The start input advances by one, modulo 4, after every cycle that issues at least one grant. It holds after a cycle with no grant.
- R8: Grants for the candidates presented in cycle t appear after the clock edge that ends cycle t. Output j reports gnt_src and gnt_slot in bit fields j*2 and up.
- R9: For each issued grant, exactly the dequeue strobe of the granted input and slot is set, in the same cycle as the grant. No other strobe is set.
- R10: An output with no valid candidate routed to it issues no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Routing table write enable |
| cfg_addr | input | 8 | Routing table entry to write |
| cfg_port | input | 2 | Output port stored in that entry |
| cand_valid | input | 16 | Candidate valid, index input*4+slot |
| cand_data | input | 16 | Candidate class: 1 for data, 0 for priority |
| cand_addr | input | 128 | Candidate destination addresses, 8 bits each |
| cand_ts | input | 256 | Candidate timestamps, 16 bits each |
| occ | input | 16 | Queue occupancy per input, 4 bits each |
| gnt_valid | output | 4 | Grant issued per output |
| gnt_src | output | 8 | Granted input per output, 2 bits each |
| gnt_slot | output | 8 | Granted slot per output, 2 bits each |
| gnt_data | output | 4 | Granted class per output (1 for data) |
| deq | output | 16 | Dequeue strobe per input slot |

## Verification
The assertions check on every cycle that the grants and the dequeue strobes agree (R9). They also check that every grant points at a slot that was valid in the previous cycle (R8), that a cycle with no candidates yields no grants (R10), and that the outputs are clear right after reset (R1). Which input wins is decided by occupancy, timestamp age, the rotating start input, the routing table and class precedence. Only the bench's scenarios show this. It sweeps all occupancy patterns and a set of timestamp patterns that wrap around 65535, and it runs mixed traffic with table rewrites. All of these are compared against a model computed from the requirements.

// File: rtl/rtsel_pkg.sv
package rtsel_pkg;

    typedef enum logic {
        CLS_PRIO = 1'b0,
        CLS_DATA = 1'b1
    } rtsel_cls_e;

    // Rotating start input: next index after cur in a ring of n ports.
    function automatic int rtsel_ring_next(input int cur, input int n);
        return (cur == n - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/rtsel_route_table.sv
module rtsel_route_table #(
    parameter int NP     = 4,
    parameter int NC     = 16,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [$clog2(NP)-1:0]      cfg_port,
    input  logic [NC*ADDR_W-1:0]       look_addr,
    output logic [NC*$clog2(NP)-1:0]   look_port
);
    localparam int PW    = $clog2(NP);
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] tbl_q [DEPTH];
    logic [PW-1:0] tbl_d [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we) begin
            tbl_d[cfg_addr] = cfg_port;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                tbl_q[k] <= PW'(k);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Lookups read the registered table: a write is seen one cycle later.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            look_port[c*PW +: PW] = tbl_q[look_addr[c*ADDR_W +: ADDR_W]];
        end
    end

endmodule

// File: rtl/rtsel_offer.sv
module rtsel_offer #(
    parameter int NP   = 4,
    parameter int NS   = 4,
    parameter int PW   = 2,
    parameter int SW   = 2,
    parameter int TS_W = 16
) (
    input  logic [NS-1:0]      slot_valid,
    input  logic [NS-1:0]      slot_data,
    input  logic [NS*PW-1:0]   slot_port,
    input  logic [NS*TS_W-1:0] slot_ts,
    output logic [NP-1:0]      p_ok,
    output logic [NP*SW-1:0]   p_slot,
    output logic [NP-1:0]      d_ok,
    output logic [NP*SW-1:0]   d_slot,
    output logic [NP*TS_W-1:0] d_ts
);
    // Per output: lowest-numbered matching slot of each class.
    always_comb begin
        p_ok   = '0;
        p_slot = '0;
        d_ok   = '0;
        d_slot = '0;
        d_ts   = '0;
        for (int j = 0; j < NP; j++) begin
            for (int s = NS - 1; s >= 0; s--) begin
                if (slot_valid[s] && slot_port[s*PW +: PW] == PW'(j)) begin
                    if (slot_data[s]) begin
                        d_ok[j]                = 1'b1;
                        d_slot[j*SW +: SW]     = SW'(s);
                        d_ts[j*TS_W +: TS_W]   = slot_ts[s*TS_W +: TS_W];
                    end else begin
                        p_ok[j]                = 1'b1;
                        p_slot[j*SW +: SW]     = SW'(s);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtsel_out_arb.sv
module rtsel_out_arb
    import rtsel_pkg::*;
#(
    parameter int NP    = 4,
    parameter int IW    = 2,
    parameter int SW    = 2,
    parameter int OCC_W = 4,
    parameter int TS_W  = 16
) (
    input  logic [IW-1:0]       start,
    input  logic [NP-1:0]       p_ok,
    input  logic [NP*SW-1:0]    p_slot,
    input  logic [NP*OCC_W-1:0] occ,
    input  logic [NP-1:0]       d_ok,
    input  logic [NP*SW-1:0]    d_slot,
    input  logic [NP*TS_W-1:0]  d_ts,
    output logic                win_valid,
    output logic [IW-1:0]       win_src,
    output logic [SW-1:0]       win_slot,
    output rtsel_cls_e          win_cls
);
    function automatic logic ts_earlier(input logic [TS_W-1:0] a,
                                        input logic [TS_W-1:0] b);
        logic [TS_W-1:0] gap;
        gap = b - a;
        return (gap != '0) && !gap[TS_W-1];
    endfunction

    logic             pf, df;
    logic [OCC_W-1:0] best_occ;
    logic [TS_W-1:0]  best_ts;
    logic [IW-1:0]    p_src, d_src;
    logic [SW-1:0]    p_sl, d_sl;
    int               ii;

    always_comb begin
        pf       = 1'b0;
        df       = 1'b0;
        best_occ = '0;
        best_ts  = '0;
        p_src    = '0;
        d_src    = '0;
        p_sl     = '0;
        d_sl     = '0;
        ii       = 0;
        for (int k = 0; k < NP; k++) begin
            ii = (int'(start) + k) % NP;
            if (p_ok[ii] && (!pf || occ[ii*OCC_W +: OCC_W] > best_occ)) begin
                pf       = 1'b1;
                best_occ = occ[ii*OCC_W +: OCC_W];
                p_src    = IW'(ii);
                p_sl     = p_slot[ii*SW +: SW];
            end
            if (d_ok[ii] && (!df || ts_earlier(d_ts[ii*TS_W +: TS_W], best_ts))) begin
                df      = 1'b1;
                best_ts = d_ts[ii*TS_W +: TS_W];
                d_src   = IW'(ii);
                d_sl    = d_slot[ii*SW +: SW];
            end
        end
        win_valid = pf || df;
        win_src   = pf ? p_src : d_src;
        win_slot  = pf ? p_sl  : d_sl;
        win_cls   = (!pf && df) ? CLS_DATA : CLS_PRIO;
    end

endmodule

// File: rtl/rtsel_router.sv
module rtsel_router
    import rtsel_pkg::*;
#(
    parameter int NP     = 4,
    parameter int NS     = 4,
    parameter int ADDR_W = 8,
    parameter int TS_W   = 16,
    parameter int OCC_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [$clog2(NP)-1:0]         cfg_port,
    input  logic [NP*NS-1:0]              cand_valid,
    input  logic [NP*NS-1:0]              cand_data,
    input  logic [NP*NS*ADDR_W-1:0]       cand_addr,
    input  logic [NP*NS*TS_W-1:0]         cand_ts,
    input  logic [NP*OCC_W-1:0]           occ,
    output logic [NP-1:0]                 gnt_valid,
    output logic [NP*$clog2(NP)-1:0]      gnt_src,
    output logic [NP*$clog2(NS)-1:0]      gnt_slot,
    output logic [NP-1:0]                 gnt_data,
    output logic [NP*NS-1:0]              deq
);
    localparam int NC = NP * NS;
    localparam int PW = $clog2(NP);
    localparam int IW = $clog2(NP);
    localparam int SW = $clog2(NS);

    typedef struct packed {
        logic [NP-1:0]    gv;
        logic [NP*IW-1:0] src;
        logic [NP*SW-1:0] slot;
        logic [NP-1:0]    gd;
        logic [NC-1:0]    deq;
        logic [IW-1:0]    start;
    } rtsel_state_t;

    rtsel_state_t st_d, st_q;

    logic [NC*PW-1:0] cand_port;

    rtsel_route_table #(
        .NP(NP), .NC(NC), .ADDR_W(ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_port  (cfg_port),
        .look_addr (cand_addr),
        .look_port (cand_port)
    );

    // Offers arranged by input, then transposed to be arranged by output.
    logic [NP-1:0]      off_pok  [NP];
    logic [NP*SW-1:0]   off_psl  [NP];
    logic [NP-1:0]      off_dok  [NP];
    logic [NP*SW-1:0]   off_dsl  [NP];
    logic [NP*TS_W-1:0] off_dts  [NP];

    logic [NP-1:0]      arb_pok  [NP];
    logic [NP*SW-1:0]   arb_psl  [NP];
    logic [NP-1:0]      arb_dok  [NP];
    logic [NP*SW-1:0]   arb_dsl  [NP];
    logic [NP*TS_W-1:0] arb_dts  [NP];

    logic [NP-1:0]      win_v;
    logic [NP*IW-1:0]   win_src;
    logic [NP*SW-1:0]   win_slot;
    rtsel_cls_e         win_cls [NP];

    for (genvar gi = 0; gi < NP; gi++) begin : g_in
        rtsel_offer #(
            .NP(NP), .NS(NS), .PW(PW), .SW(SW), .TS_W(TS_W)
        ) u_offer (
            .slot_valid (cand_valid[gi*NS +: NS]),
            .slot_data  (cand_data[gi*NS +: NS]),
            .slot_port  (cand_port[gi*NS*PW +: NS*PW]),
            .slot_ts    (cand_ts[gi*NS*TS_W +: NS*TS_W]),
            .p_ok       (off_pok[gi]),
            .p_slot     (off_psl[gi]),
            .d_ok       (off_dok[gi]),
            .d_slot     (off_dsl[gi]),
            .d_ts       (off_dts[gi])
        );
    end

    always_comb begin
        for (int j = 0; j < NP; j++) begin
            for (int i = 0; i < NP; i++) begin
                arb_pok[j][i]                = off_pok[i][j];
                arb_psl[j][i*SW +: SW]       = off_psl[i][j*SW +: SW];
                arb_dok[j][i]                = off_dok[i][j];
                arb_dsl[j][i*SW +: SW]       = off_dsl[i][j*SW +: SW];
                arb_dts[j][i*TS_W +: TS_W]   = off_dts[i][j*TS_W +: TS_W];
            end
        end
    end

    for (genvar gj = 0; gj < NP; gj++) begin : g_out
        rtsel_out_arb #(
            .NP(NP), .IW(IW), .SW(SW), .OCC_W(OCC_W), .TS_W(TS_W)
        ) u_arb (
            .start     (st_q.start),
            .p_ok      (arb_pok[gj]),
            .p_slot    (arb_psl[gj]),
            .occ       (occ),
            .d_ok      (arb_dok[gj]),
            .d_slot    (arb_dsl[gj]),
            .d_ts      (arb_dts[gj]),
            .win_valid (win_v[gj]),
            .win_src   (win_src[gj*IW +: IW]),
            .win_slot  (win_slot[gj*SW +: SW]),
            .win_cls   (win_cls[gj])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.gv    = win_v;
        st_d.src   = win_src;
        st_d.slot  = win_slot;
        st_d.deq   = '0;
        for (int j = 0; j < NP; j++) begin
            st_d.gd[j] = win_v[j] && (win_cls[j] == CLS_DATA);
            if (win_v[j]) begin
                st_d.deq[int'(win_src[j*IW +: IW]) * NS + int'(win_slot[j*SW +: SW])] = 1'b1;
            end
        end
        if (|win_v) begin
            st_d.start = IW'(rtsel_ring_next(int'(st_q.start), NP));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_valid = st_q.gv;
    assign gnt_src   = st_q.src;
    assign gnt_slot  = st_q.slot;
    assign gnt_data  = st_q.gd;
    assign deq       = st_q.deq;

endmodule

// File: rtl/rtsel_checker.sv
module rtsel_checker #(
    parameter int NP = 4,
    parameter int NS = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NP*NS-1:0]         cand_valid,
    input logic [NP-1:0]            gnt_valid,
    input logic [NP*$clog2(NP)-1:0] gnt_src,
    input logic [NP*$clog2(NS)-1:0] gnt_slot,
    input logic [NP*NS-1:0]         deq
);
    localparam int IW = $clog2(NP);
    localparam int SW = $clog2(NS);

    logic [NP*NS-1:0] seen_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_valid_q <= '0;
        end else begin
            seen_valid_q <= cand_valid;
        end
    end

    for (genvar gj = 0; gj < NP; gj++) begin : g_chk
        logic [IW-1:0] g_src;
        logic [SW-1:0] g_slot;
        assign g_src  = gnt_src[gj*IW +: IW];
        assign g_slot = gnt_slot[gj*SW +: SW];

        assert_grant_was_valid_R8: assert property (@(posedge clk) disable iff (rst)
            gnt_valid[gj] |-> seen_valid_q[int'(g_src) * NS + int'(g_slot)]);

        assert_grant_strobes_slot_R9: assert property (@(posedge clk) disable iff (rst)
            gnt_valid[gj] |-> deq[int'(g_src) * NS + int'(g_slot)]);
    end

    assert_strobe_count_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(deq) == $countones(gnt_valid));

    assert_idle_no_grant_R10: assert property (@(posedge clk) disable iff (rst)
        (cand_valid == '0) |=> (gnt_valid == '0));

    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gnt_valid == '0 && deq == '0));

endmodule

bind rtsel_router rtsel_checker #(.NP(NP), .NS(NS)) u_rtsel_chk (
    .clk        (clk),
    .rst        (rst),
    .cand_valid (cand_valid),
    .gnt_valid  (gnt_valid),
    .gnt_src    (gnt_src),
    .gnt_slot   (gnt_slot),
    .deq        (deq)
);

// File: tb/tb_rtsel_router.sv
module tb_rtsel_router;
    localparam int NP = 4;
    localparam int NS = 4;
    localparam int NC = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [7:0]      cfg_addr = '0;
    logic [1:0]      cfg_port = '0;
    logic [NC-1:0]   cand_valid = '0;
    logic [NC-1:0]   cand_data = '0;
    logic [NC*8-1:0] cand_addr = '0;
    logic [NC*16-1:0] cand_ts = '0;
    logic [15:0]     occ = '0;
    logic [3:0]      gnt_valid;
    logic [7:0]      gnt_src;
    logic [7:0]      gnt_slot;
    logic [3:0]      gnt_data;
    logic [NC-1:0]   deq;

    rtsel_router dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_port(cfg_port), .cand_valid(cand_valid), .cand_data(cand_data),
        .cand_addr(cand_addr), .cand_ts(cand_ts), .occ(occ),
        .gnt_valid(gnt_valid), .gnt_src(gnt_src), .gnt_slot(gnt_slot),
        .gnt_data(gnt_data), .deq(deq)
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Stimulus and model state
    bit         sv [NC];
    bit         sd [NC];
    logic [7:0] sa [NC];
    logic [15:0] st [NC];
    logic [3:0] so [NP];
    logic [1:0] rtab [256];
    int         mstart = 0;

    function automatic bit earlier(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] g;
        g = b - a;
        return (g != 16'd0) && (g < 16'h8000);
    endfunction

    task automatic clear_stim();
        for (int c = 0; c < NC; c++) begin
            sv[c] = 0; sd[c] = 0; sa[c] = '0; st[c] = '0;
        end
        for (int i = 0; i < NP; i++) so[i] = '0;
        cfg_we = 1'b0;
    endtask

    task automatic drive();
        for (int c = 0; c < NC; c++) begin
            cand_valid[c]       = sv[c];
            cand_data[c]        = sd[c];
            cand_addr[c*8 +: 8] = sa[c];
            cand_ts[c*16 +: 16] = st[c];
        end
        for (int i = 0; i < NP; i++) occ[i*4 +: 4] = so[i];
    endtask

    // Called at a falling edge; checks after the next falling edge.
    task automatic cycle(input string tag);
        bit ev [NP]; int es [NP]; int esl [NP]; bit ed [NP];
        logic [NC-1:0] edeq;
        bit any;
        edeq = '0;
        any = 0;
        drive();
        for (int j = 0; j < NP; j++) begin
            bit pok [NP]; int psl [NP]; bit dok [NP]; int dsl [NP];
            bit pf, df; int bo; logic [15:0] bt; int pi, pis, di, dis;
            for (int i = 0; i < NP; i++) begin
                pok[i] = 0; dok[i] = 0; psl[i] = 0; dsl[i] = 0;
                for (int s = NS - 1; s >= 0; s--) begin
                    if (sv[i*NS+s] && rtab[sa[i*NS+s]] == 2'(j)) begin
                        if (sd[i*NS+s]) begin dok[i] = 1; dsl[i] = s; end
                        else begin pok[i] = 1; psl[i] = s; end
                    end
                end
            end
            pf = 0; df = 0; bo = 0; bt = '0; pi = 0; pis = 0; di = 0; dis = 0;
            for (int k = 0; k < NP; k++) begin
                int ii;
                ii = (mstart + k) % NP;
                if (pok[ii] && (!pf || int'(so[ii]) > bo)) begin
                    pf = 1; bo = int'(so[ii]); pi = ii; pis = psl[ii];
                end
                if (dok[ii] && (!df || earlier(st[ii*NS+dsl[ii]], bt))) begin
                    df = 1; bt = st[ii*NS+dsl[ii]]; di = ii; dis = dsl[ii];
                end
            end
            ev[j]  = pf || df;
            es[j]  = pf ? pi : di;
            esl[j] = pf ? pis : dis;
            ed[j]  = !pf && df;
            if (ev[j]) begin
                edeq[es[j]*NS + esl[j]] = 1'b1;
                any = 1;
            end
        end
        @(negedge clk);
        for (int j = 0; j < NP; j++) begin
            bit ok;
            ok = (gnt_valid[j] == ev[j]);
            if (ev[j]) begin
                ok = ok && int'(gnt_src[j*2 +: 2]) == es[j]
                        && int'(gnt_slot[j*2 +: 2]) == esl[j]
                        && gnt_data[j] == ed[j];
            end
            n_tests++;
            if (!ok) begin
                n_fail++;
                $display("FAIL %s R8 out%0d: got v=%0d src=%0d slot=%0d data=%0d, expected v=%0d src=%0d slot=%0d data=%0d",
                         tag, j, gnt_valid[j], gnt_src[j*2 +: 2], gnt_slot[j*2 +: 2],
                         gnt_data[j], ev[j], es[j], esl[j], ed[j]);
            end
        end
        n_tests++;
        if (deq !== edeq) begin
            n_fail++;
            $display("FAIL %s R9 dequeue: got %h, expected %h", tag, deq, edeq);
        end
        if (any) mstart = (mstart + 1) % NP;   // R7 model
        if (cfg_we) rtab[cfg_addr] = cfg_port;  // R2 model: seen next cycle
    endtask

    initial begin
        for (int k = 0; k < 256; k++) rtab[k] = 2'(k);
        clear_stim();
        drive();
        repeat (3) @(negedge clk);
        // R1: outputs clear while in reset
        n_tests++;
        if (gnt_valid !== '0 || deq !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: got gnt=%b deq=%h, expected 0 and 0", gnt_valid, deq);
        end
        rst = 1'b0;
        cycle("R1");
        cycle("R10");

        // R5: every occupancy pattern, all inputs offering priority to every output
        for (int n = 0; n < 256; n++) begin
            clear_stim();
            for (int i = 0; i < NP; i++) begin
                so[i] = 4'((n >> (2*i)) & 3);
                for (int s = 0; s < NS; s++) begin
                    sv[i*NS+s] = 1; sd[i*NS+s] = 0; sa[i*NS+s] = 8'(s);
                end
            end
            cycle("R5");
        end

        // R6: timestamps straddling the 16-bit wrap
        for (int n = 0; n < 256; n++) begin
            clear_stim();
            for (int i = 0; i < NP; i++) begin
                for (int s = 0; s < NS; s++) begin
                    sv[i*NS+s] = 1; sd[i*NS+s] = 1; sa[i*NS+s] = 8'(4*s + 1);
                    st[i*NS+s] = 16'hFFFE + 16'((n >> (2*i)) & 3);
                end
            end
            cycle("R6");
        end

        // R3: lowest matching slot per class is offered
        clear_stim();
        sv[8] = 1; sd[8] = 1; sa[8] = 8'd1;
        sv[9] = 1; sd[9] = 0; sa[9] = 8'd5;
        sv[10] = 1; sd[10] = 0; sa[10] = 8'd3;
        sv[11] = 1; sd[11] = 0; sa[11] = 8'd9;
        sv[12] = 1; sd[12] = 1; sa[12] = 8'd13; st[12] = 16'd7;
        cycle("R3");

        // R2: write not seen in its own cycle, seen in the next
        clear_stim();
        sv[0] = 1; sa[0] = 8'h55;
        cfg_we = 1'b1; cfg_addr = 8'h55; cfg_port = 2'd3;
        cycle("R2");
        cfg_we = 1'b0;
        cycle("R2");

        // R10 then R7: idle cycle must not move the start input
        clear_stim();
        cycle("R10");
        for (int i = 0; i < NP; i++) begin
            sv[i*NS] = 1; sa[i*NS] = 8'd0; so[i] = 4'd5;
        end
        cycle("R7");
        cycle("R7");

        // R4: mixed classes, random routes and occasional table writes
        for (int n = 0; n < 400; n++) begin
            clear_stim();
            for (int c = 0; c < NC; c++) begin
                sv[c] = 1'($urandom_range(0, 1));
                sd[c] = 1'($urandom_range(0, 1));
                sa[c] = 8'($urandom_range(0, 255));
                st[c] = 16'($urandom_range(0, 65535));
            end
            for (int i = 0; i < NP; i++) so[i] = 4'($urandom_range(0, 15));
            cfg_we   = ($urandom_range(0, 3) == 0);
            cfg_addr = 8'($urandom_range(0, 255));
            cfg_port = 2'($urandom_range(0, 3));
            cycle("R4");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule